// File: doc/BRIEF.md
# Analog Run-Mode Sequencer

This block steps an analog computing array through one run. From idle it enters the initial-condition phase, in which the integrators load their start values. It then enters the operate phase, in which they integrate. The run finishes in one of three ways: the operate time runs out, an overload is detected, or an external halt request pauses the run. Two active-low mode lines carry the phase to the analog side. Five registered flags give the phase to the controller.

Each phase duration is a product of two counters. A prescaler of `PRE_W` bits feeds a main counter of `CNT_W` bits. With the default 16-bit counters and a fast clock, this covers sub-microsecond through multi-second phases. Software can start a run by a pulse. In a synchronized setup, an external trigger starts the run instead. Software can also write any state directly through a force port.

Two policy inputs control how the operate phase reacts to the analog side. One decides whether an overload stops the run. The other decides whether an external halt request pauses it. A paused run resumes when the request is released, and it then runs a complete operate duration again.

Top module: `run_sequencer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the block is idle: `is_idle`=1, `ic_n`=1, `op_n`=1 and all other flags are 0.
- R2: `ic_n` is low only in the initial-condition state. `op_n` is low only in the operate state. Both lines are high in every other state, and they are never low together. `is_op` is 1 exactly when `op_n` is 0.
- R3: The initial-condition state lasts (`ic_pre`+1)*(`ic_cnt`+1) clock cycles. The machine then enters the operate state.
- R4: When no stop condition occurs, the operate state lasts (`op_pre`+1)*(`op_cnt`+1) cycles. The machine then enters the end state, where `is_done`=1 and `is_overload`=0.
- R5: The operate state is left by the first condition that holds, in this order: time expired (to end), overload (to overload state), external halt (to halt state).
- R6: When `ovl_stop`=1 and `ovl_n`=0 in the operate state, the next state is the overload state, with `is_overload`=1 and `is_done`=1. When `ovl_stop`=0, `ovl_n` has no effect.
- R7: When `halt_pause`=1 and `xhalt_n`=0 in the operate state, the next state is the halt state (`is_halted`=1). When `halt_pause`=0, the machine stays in the operate state.
- R8: The halt state is held while `xhalt_n`=0, whatever the other inputs are. Once `xhalt_n`=1 the machine returns to the operate state, and that operate state then lasts its complete duration.
- R9: The end and overload states are left only by reset or a force write. Start, trigger and analog inputs do not move them.
- R10: When `sync_sel`=0, a `start` pulse moves idle to the initial-condition state and `sync_trig` is ignored. When `sync_sel` is nonzero, `sync_trig` does this and `start` is ignored.
- R11: A `force_we` pulse loads the state code on `force_state`: 0 idle, 1 initial condition, 2 operate, 3 end, 4 overload, 5 halt. The load takes priority over all other transitions, and the phase counters restart. Codes 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Software start pulse (unsynchronized mode) |
| sync_trig | input | 1 | External run trigger (synchronized modes) |
| sync_sel | input | 2 | 0 unsynchronized, nonzero synchronized |
| ovl_stop | input | 1 | 1: overload ends the run; 0: overload is ignored |
| halt_pause | input | 1 | 1: external halt pauses the run; 0: it is ignored |
| ovl_n | input | 1 | Overload indication, active low |
| xhalt_n | input | 1 | External halt request, active low |
| ic_pre | input | PRE_W | Initial-condition prescaler limit |
| ic_cnt | input | CNT_W | Initial-condition main counter limit |
| op_pre | input | PRE_W | Operate prescaler limit |
| op_cnt | input | CNT_W | Operate main counter limit |
| force_we | input | 1 | Force-state write strobe |
| force_state | input | 3 | State code to force |
| ic_n | output | 1 | Initial-condition mode line, active low |
| op_n | output | 1 | Operate mode line, active low |
| is_idle | output | 1 | Idle state |
| is_op | output | 1 | Operate state |
| is_done | output | 1 | End or overload state |
| is_overload | output | 1 | Overload state |
| is_halted | output | 1 | External halt state |

## Verification
The checker tests the following on every cycle. The mode lines never overlap and at most one status flag is set. Terminal states persist, and a held halt stays held. An ignore policy never leads to the overload or halt state, and idle in a synchronized mode waits for its trigger. Phase lengths, the OP exit priority at the expiry cycle, the full restart of OP after a halt, and the rejection of invalid force codes depend on counts and ordering over many cycles. The bench's directed scenarios and its table of duration vectors show these.

// File: rtl/run_seq_pkg.sv
package run_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_IC   = 3'd1,
    ST_OP   = 3'd2,
    ST_END  = 3'd3,
    ST_OVL  = 3'd4,
    ST_HALT = 3'd5
  } run_state_t;

  localparam logic [2:0] LAST_VALID_CODE = 3'd5;
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_lim,
  input  logic [CNT_W-1:0] cnt_lim,
  output logic             expire
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == pre_lim);
  assign expire   = run && pre_wrap && (cnt_q == cnt_lim);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/run_seq_next.sv
module run_seq_next
  import run_seq_pkg::*;
(
  input  run_state_t cur,
  input  logic       start,
  input  logic       sync_trig,
  input  logic [1:0] sync_sel,
  input  logic       ovl_stop,
  input  logic       halt_pause,
  input  logic       ovl_n,
  input  logic       xhalt_n,
  input  logic       ic_done,
  input  logic       op_done,
  input  logic       force_we,
  input  logic [2:0] force_state,
  output run_state_t nxt
);
  logic go;
  logic ovl_hit;
  logic halt_hit;

  assign go       = (sync_sel == 2'd0) ? start : sync_trig;
  assign ovl_hit  = ovl_stop && !ovl_n;
  assign halt_hit = halt_pause && !xhalt_n;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE: if (go) nxt = ST_IC;
      ST_IC:   if (ic_done) nxt = ST_OP;
      ST_OP: begin
        if (op_done)       nxt = ST_END;
        else if (ovl_hit)  nxt = ST_OVL;
        else if (halt_hit) nxt = ST_HALT;
      end
      ST_HALT: if (xhalt_n) nxt = ST_OP;
      ST_END:  nxt = ST_END;
      ST_OVL:  nxt = ST_OVL;
      default: nxt = ST_IDLE;
    endcase
    if (force_we && force_state <= LAST_VALID_CODE)
      nxt = run_state_t'(force_state);
  end
endmodule

// File: rtl/run_sequencer.sv
module run_sequencer
  import run_seq_pkg::*;
#(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             sync_trig,
  input  logic [1:0]       sync_sel,
  input  logic             ovl_stop,
  input  logic             halt_pause,
  input  logic             ovl_n,
  input  logic             xhalt_n,
  input  logic [PRE_W-1:0] ic_pre,
  input  logic [CNT_W-1:0] ic_cnt,
  input  logic [PRE_W-1:0] op_pre,
  input  logic [CNT_W-1:0] op_cnt,
  input  logic             force_we,
  input  logic [2:0]       force_state,
  output logic             ic_n,
  output logic             op_n,
  output logic             is_idle,
  output logic             is_op,
  output logic             is_done,
  output logic             is_overload,
  output logic             is_halted
);
  run_state_t st_q;
  run_state_t st_nxt;
  logic       ic_done;
  logic       op_done;
  logic       restart;

  assign restart = force_we;

  phase_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_ic_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q == ST_IC),
    .restart (restart),
    .pre_lim (ic_pre),
    .cnt_lim (ic_cnt),
    .expire  (ic_done)
  );

  phase_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_op_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (st_q == ST_OP),
    .restart (restart),
    .pre_lim (op_pre),
    .cnt_lim (op_cnt),
    .expire  (op_done)
  );

  run_seq_next u_next (
    .cur         (st_q),
    .start       (start),
    .sync_trig   (sync_trig),
    .sync_sel    (sync_sel),
    .ovl_stop    (ovl_stop),
    .halt_pause  (halt_pause),
    .ovl_n       (ovl_n),
    .xhalt_n     (xhalt_n),
    .ic_done     (ic_done),
    .op_done     (op_done),
    .force_we    (force_we),
    .force_state (force_state),
    .nxt         (st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      ic_n        <= 1'b1;
      op_n        <= 1'b1;
      is_idle     <= 1'b1;
      is_op       <= 1'b0;
      is_done     <= 1'b0;
      is_overload <= 1'b0;
      is_halted   <= 1'b0;
    end else begin
      st_q        <= st_nxt;
      ic_n        <= (st_nxt != ST_IC);
      op_n        <= (st_nxt != ST_OP);
      is_idle     <= (st_nxt == ST_IDLE);
      is_op       <= (st_nxt == ST_OP);
      is_done     <= (st_nxt == ST_END) || (st_nxt == ST_OVL);
      is_overload <= (st_nxt == ST_OVL);
      is_halted   <= (st_nxt == ST_HALT);
    end
  end
endmodule

// File: rtl/run_sequencer_sva.sv
module run_sequencer_sva #(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             sync_trig,
  input logic [1:0]       sync_sel,
  input logic             ovl_stop,
  input logic             halt_pause,
  input logic             ovl_n,
  input logic             xhalt_n,
  input logic [PRE_W-1:0] ic_pre,
  input logic [CNT_W-1:0] ic_cnt,
  input logic [PRE_W-1:0] op_pre,
  input logic [CNT_W-1:0] op_cnt,
  input logic             force_we,
  input logic [2:0]       force_state,
  input logic             ic_n,
  input logic             op_n,
  input logic             is_idle,
  input logic             is_op,
  input logic             is_done,
  input logic             is_overload,
  input logic             is_halted
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (is_idle && ic_n && op_n && !is_done && !is_halted));

  a_r2_lines_apart: assert property (@(posedge clk) disable iff (rst)
    !(!ic_n && !op_n));

  a_r2_op_flag_line: assert property (@(posedge clk) disable iff (rst)
    is_op == !op_n);

  a_r2_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_idle, is_op, is_done, is_halted}));

  a_r6_ovl_ignored: assert property (@(posedge clk) disable iff (rst)
    (is_op && !ovl_stop && !force_we) |=> !is_overload);

  a_r7_halt_ignored: assert property (@(posedge clk) disable iff (rst)
    (is_op && !halt_pause && !force_we) |=> !is_halted);

  a_r8_halt_held: assert property (@(posedge clk) disable iff (rst)
    (is_halted && !xhalt_n && !force_we) |=> is_halted);

  a_r9_terminal_kept: assert property (@(posedge clk) disable iff (rst)
    (is_done && !force_we) |=> (is_done && $stable(is_overload)));

  a_r10_sync_waits: assert property (@(posedge clk) disable iff (rst)
    (is_idle && sync_sel != 2'd0 && !sync_trig && !force_we) |=> is_idle);
endmodule

bind run_sequencer run_sequencer_sva #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_sva (.*);

// File: tb/run_sequencer_test.sv
module run_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 16;
  localparam int CW = 16;
  // columns: ic_pre, ic_cnt, op_pre, op_cnt, expected IC cycles, expected OP cycles
  localparam int NVEC = 5;
  localparam int VEC [NVEC][6] = '{
    '{0, 0, 0, 0, 1, 1},
    '{1, 2, 2, 1, 6, 6},
    '{3, 0, 0, 4, 4, 5},
    '{2, 2, 1, 3, 9, 8},
    '{0, 6, 4, 2, 7, 15}
  };

  logic clk = 0;
  logic rst, start, sync_trig, ovl_stop, halt_pause, ovl_n, xhalt_n, force_we;
  logic [1:0] sync_sel;
  logic [2:0] force_state;
  logic [PW-1:0] ic_pre, op_pre;
  logic [CW-1:0] ic_cnt, op_cnt;
  logic ic_n, op_n, is_idle, is_op, is_done, is_overload, is_halted;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  run_sequencer #(.PRE_W(PW), .CNT_W(CW)) uut (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; start = 0; sync_trig = 0; sync_sel = 0; ovl_stop = 1;
    halt_pause = 0; ovl_n = 1; xhalt_n = 1; force_we = 0; force_state = 0;
    step(); step();
    rst = 0;
  endtask

  task automatic set_times(int a, int b, int c, int d);
    ic_pre = PW'(a); ic_cnt = CW'(b); op_pre = PW'(c); op_cnt = CW'(d);
  endtask

  // start a run, returns the measured IC length; afterwards first OP cycle is sampled
  task automatic launch(output int ic_len);
    start = 1; step(); start = 0;
    ic_len = 0;
    while (!ic_n && ic_len < 1000) begin ic_len++; step(); end
  endtask

  task automatic count_op(output int op_len);
    op_len = 0;
    while (!op_n && op_len < 1000) begin op_len++; step(); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int m;
    set_times(0, 0, 0, 0);
    do_reset();
    // R1 reset state
    chk("R1 idle", is_idle, 1);
    chk("R1 ic_n", ic_n, 1);
    chk("R1 op_n", op_n, 1);
    chk("R1 done", is_done, 0);

    // table of durations: R3, R4, R2
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      set_times(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      launch(n);
      chk("R3 ic length", n, VEC[v][4]);
      chk("R2 op line in OP", op_n, 0);
      chk("R2 ic line in OP", ic_n, 1);
      count_op(m);
      chk("R4 op length", m, VEC[v][5]);
      chk("R4 done", is_done, 1);
      chk("R4 not overload", is_overload, 0);
      chk("R2 lines high at end", ic_n & op_n, 1);
    end

    // R6 overload stops run
    do_reset(); set_times(0, 1, 0, 50);
    launch(n); step(); step();
    ovl_n = 0; step();
    chk("R6 overload state", is_overload, 1);
    chk("R6 done", is_done, 1);
    // R9 terminal: inputs do not move it
    ovl_n = 1; start = 1; sync_trig = 1; step(); step();
    start = 0; sync_trig = 0;
    chk("R9 overload held", is_overload, 1);
    chk("R9 lines high", ic_n & op_n, 1);

    // R6 overload ignored
    do_reset(); set_times(0, 0, 1, 2); ovl_stop = 0;
    launch(n); ovl_n = 0;
    count_op(m);
    chk("R6 ignored op length", m, 6);
    chk("R6 ignored no overload", is_overload, 0);
    ovl_n = 1;

    // R5 time-over beats overload at the expiry cycle
    do_reset(); set_times(0, 0, 0, 3);
    launch(n); step(); step(); step();
    ovl_n = 0; xhalt_n = 0; halt_pause = 1; step();
    chk("R5 end wins", is_done, 1);
    chk("R5 not overload", is_overload, 0);
    ovl_n = 1; xhalt_n = 1;
    // R5 overload beats halt
    do_reset(); set_times(0, 0, 0, 20); halt_pause = 1;
    launch(n); ovl_n = 0; xhalt_n = 0; step();
    chk("R5 overload over halt", is_overload, 1);
    chk("R5 not halted", is_halted, 0);
    ovl_n = 1; xhalt_n = 1;

    // R7 / R8 pause and full restart
    do_reset(); set_times(0, 0, 1, 4); halt_pause = 1;
    launch(n); step(); step(); step();
    xhalt_n = 0; step();
    chk("R7 halted", is_halted, 1);
    ovl_n = 0; start = 1; step(); step(); step();
    chk("R8 halt holds", is_halted, 1);
    chk("R8 lines high", ic_n & op_n, 1);
    ovl_n = 1; start = 0; xhalt_n = 1; step();
    chk("R8 back to op", is_op, 1);
    count_op(m);
    chk("R8 full op restart", m, 10);
    // R7 ignored
    do_reset(); set_times(0, 0, 0, 3); halt_pause = 0;
    launch(n); xhalt_n = 0;
    count_op(m);
    chk("R7 ignored op length", m, 4);
    chk("R7 ignored not halted", is_halted, 0);
    xhalt_n = 1;

    // R10 sync modes
    do_reset(); sync_sel = 2'd1;
    start = 1; step(); step(); start = 0;
    chk("R10 start ignored in sync", is_idle, 1);
    sync_trig = 1; step(); sync_trig = 0;
    chk("R10 trigger enters IC", ic_n, 0);
    do_reset(); sync_sel = 2'd0;
    sync_trig = 1; step(); step(); sync_trig = 0;
    chk("R10 trigger ignored unsynced", is_idle, 1);

    // R11 force writes
    do_reset();
    force_state = 3'd7; force_we = 1; step(); force_we = 0;
    chk("R11 invalid code ignored", is_idle, 1);
    force_state = 3'd3; force_we = 1; step(); force_we = 0;
    chk("R11 force end", is_done, 1);
    chk("R9 end not overload", is_overload, 0);
    set_times(0, 2, 0, 0);
    force_state = 3'd1; force_we = 1; step(); force_we = 0;
    chk("R11 force out of terminal", ic_n, 0);
    n = 0;
    while (!ic_n && n < 1000) begin n++; step(); end
    chk("R11 forced IC length", n, 3);
    set_times(0, 0, 0, 5);
    step(); step(); step();
    force_state = 3'd2; force_we = 1; step(); force_we = 0;
    count_op(m);
    chk("R11 force restarts op", m, 6);

    // R1 reset mid-run
    set_times(0, 0, 0, 40);
    force_state = 3'd2; force_we = 1; step(); force_we = 0;
    rst = 1; step(); rst = 0;
    chk("R1 reset mid-run", is_idle, 1);
    chk("R1 reset op line", op_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule